// File: doc/BRIEF.md
# Slowdown-Balancing Fair Scheduler Selector

This block sits beside a memory request scheduler and decides, every cycle, which prioritisation mode the scheduler applies. For each of up to four threads it keeps a saturating count of the cycles the thread spent stalled while sharing memory. It also receives from outside an estimate of the stall time the thread would have seen running alone. The ratio of the two is the thread's slowdown.

Among the threads that currently hold legal requests, the block finds the most and the least slowed threads. It compares the ratio of their slowdowns against a programmable fixed-point threshold. When the spread is below the threshold, the scheduler keeps its throughput policy: row hits first, then the oldest request. When the spread reaches the threshold, fairness mode is flagged and the scheduler puts the requests of the reported most-slowed thread ahead of row hits and age. All ratios are compared by cross-multiplication, so no divider is needed.

Top module: `slowdown_fair_sel`

## Requirements
- R1: The shared stall count of thread i rises by one on each rising clock edge at which `stall_i[i]` is 1, and keeps its value on edges at which it is 0; all counts are 0 after reset.
- R2: A shared stall count that has reached 2^STW-1 stays there while stalls continue; it never wraps.
- R3: The slowdown of thread i is shared_count[i] / alone[i], where alone[i] is the STW-bit field `alone_i[i*STW +: STW]` and an alone value of 0 is taken as 1. `hog_idx_o` names the eligible thread with the largest slowdown, the lowest index winning a tie, and is 0 when no thread is eligible.
- R4: A thread is eligible only while its bit in `pend_i` is 1; threads with the bit at 0 affect neither output.
- R5: With Smax/Amax the most and Smin/Amin the least slowed eligible thread, `fair_mode_o` is 1 exactly when 16*Smax*Amin >= T*Smin*Amax, with T = `thresh_i` read as an unsigned value with 4 fraction bits; equality selects fairness mode.
- R6: With fewer than two eligible threads, `fair_mode_o` is 0.
- R7: When the most slowed eligible thread has a shared count of 0, `fair_mode_o` is 0.
- R8: Both outputs are combinational in the current counts and inputs, so a count change is visible in the cycle after the edge that made it, and the decision is recomputed every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_i | input | NTHR | Per thread: an outstanding request is stalled this cycle |
| pend_i | input | NTHR | Per thread: a legal request is waiting |
| alone_i | input | NTHR*STW | Estimated alone stall time, field i at bits i*STW +: STW |
| thresh_i | input | THW | Unfairness threshold, 4 fraction bits |
| fair_mode_o | output | 1 | 1 = fairness policy, 0 = throughput policy |
| hog_idx_o | output | $clog2(NTHR) | Index of the most slowed eligible thread |

## Verification
Stall counts are built up per thread, and the selector is then queried under different eligible masks, alone estimates and thresholds. Full eligibility against a subset tells whether non-pending threads are correctly ignored. Thresholds just at and just above the slowdown spread separate a strict compare from an inclusive one. Equal alone values against differing ones tell a real ratio from a raw count compare, and a zero alone value probes the floor at one. Long joint stalls that run past the count limit, ending in a tie, show saturation against wrap-around and the lowest-index tie rule.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  typedef logic [31:0] cnt_t;

  // a/b > c/d, all unsigned, by cross-multiplication
  function automatic logic ratio_gt(cnt_t sa, cnt_t aa, cnt_t sb, cnt_t ab);
    return (64'(sa) * 64'(ab)) > (64'(sb) * 64'(aa));
  endfunction

  // (smax/amax) / (smin/amin) >= thr/16
  function automatic logic spread_ge(cnt_t smax, cnt_t amax, cnt_t smin, cnt_t amin,
                                     logic [15:0] thr);
    logic [95:0] lhs, rhs;
    lhs = 96'(smax) * 96'(amin) * 96'd16;
    rhs = 96'(thr) * 96'(smin) * 96'(amax);
    return lhs >= rhs;
  endfunction
endpackage

// File: rtl/sfs_stall_ctr.sv
module sfs_stall_ctr #(
  parameter int STW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           stall_i,
  output logic [STW-1:0] cnt_o
);
  localparam logic [STW-1:0] CMAX = '1;

  logic at_max;
  assign at_max = (cnt_o == CMAX);

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_o <= '0;
    else if (stall_i && !at_max) cnt_o <= cnt_o + 1'b1;
  end

  p_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_i && !at_max) |=> (cnt_o == $past(cnt_o) + 1'b1));
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_i |=> $stable(cnt_o));
  p_no_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    at_max |=> (cnt_o == CMAX));
endmodule

// File: rtl/sfs_extreme_pick.sv
module sfs_extreme_pick
  import sfs_pkg::*;
#(
  parameter int NTHR = 4,
  parameter int STW  = 16,
  localparam int IDXW = $clog2(NTHR)
) (
  input  logic [NTHR*STW-1:0] shared_i,
  input  logic [NTHR*STW-1:0] alone_i,
  input  logic [NTHR-1:0]     elig_i,
  output logic [IDXW-1:0]     max_idx_o,
  output logic [IDXW-1:0]     min_idx_o,
  output logic                multi_o
);
  cnt_t s [NTHR];
  cnt_t a [NTHR];

  for (genvar g = 0; g < NTHR; g++) begin : g_unpack
    assign s[g] = cnt_t'(shared_i[g*STW +: STW]);
    assign a[g] = cnt_t'(alone_i[g*STW +: STW]);
  end

  always_comb begin
    logic found;
    found     = 1'b0;
    max_idx_o = '0;
    min_idx_o = '0;
    for (int i = 0; i < NTHR; i++) begin
      if (elig_i[i]) begin
        if (!found || ratio_gt(s[i], a[i], s[max_idx_o], a[max_idx_o]))
          max_idx_o = IDXW'(i);
        if (!found || ratio_gt(s[min_idx_o], a[min_idx_o], s[i], a[i]))
          min_idx_o = IDXW'(i);
        found = 1'b1;
      end
    end
  end

  assign multi_o = ($countones(elig_i) >= 2);
endmodule

// File: rtl/sfs_mode_cmp.sv
module sfs_mode_cmp
  import sfs_pkg::*;
#(
  parameter int STW = 16,
  parameter int THW = 8
) (
  input  logic [STW-1:0] smax_i,
  input  logic [STW-1:0] amax_i,
  input  logic [STW-1:0] smin_i,
  input  logic [STW-1:0] amin_i,
  input  logic [THW-1:0] thr_i,
  input  logic           multi_i,
  output logic           fair_o
);
  logic spread_hit;
  assign spread_hit = spread_ge(cnt_t'(smax_i), cnt_t'(amax_i), cnt_t'(smin_i),
                                cnt_t'(amin_i), 16'(thr_i));
  assign fair_o = multi_i && (smax_i != '0) && spread_hit;
endmodule

// File: rtl/slowdown_fair_sel.sv
module slowdown_fair_sel #(
  parameter int NTHR = 4,
  parameter int STW  = 16,
  parameter int THW  = 8,
  localparam int IDXW = $clog2(NTHR)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NTHR-1:0]     stall_i,
  input  logic [NTHR-1:0]     pend_i,
  input  logic [NTHR*STW-1:0] alone_i,
  input  logic [THW-1:0]      thresh_i,
  output logic                fair_mode_o,
  output logic [IDXW-1:0]     hog_idx_o
);
  logic [NTHR*STW-1:0] shared_w;
  logic [NTHR*STW-1:0] alone_fl;
  logic [IDXW-1:0]     min_idx;
  logic                multi;

  for (genvar g = 0; g < NTHR; g++) begin : g_thr
    logic [STW-1:0] al;
    assign al = alone_i[g*STW +: STW];
    assign alone_fl[g*STW +: STW] = (al == '0) ? STW'(1) : al;

    sfs_stall_ctr #(.STW(STW)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .stall_i(stall_i[g]),
      .cnt_o  (shared_w[g*STW +: STW])
    );
  end

  sfs_extreme_pick #(.NTHR(NTHR), .STW(STW)) u_pick (
    .shared_i (shared_w),
    .alone_i  (alone_fl),
    .elig_i   (pend_i),
    .max_idx_o(hog_idx_o),
    .min_idx_o(min_idx),
    .multi_o  (multi)
  );

  sfs_mode_cmp #(.STW(STW), .THW(THW)) u_cmp (
    .smax_i (shared_w[hog_idx_o*STW +: STW]),
    .amax_i (alone_fl[hog_idx_o*STW +: STW]),
    .smin_i (shared_w[min_idx*STW +: STW]),
    .amin_i (alone_fl[min_idx*STW +: STW]),
    .thr_i  (thresh_i),
    .multi_i(multi),
    .fair_o (fair_mode_o)
  );

  p_hog_elig_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i != '0) |-> pend_i[hog_idx_o]);
  p_min_elig_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i != '0) |-> pend_i[min_idx]);
  p_few_thru_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(pend_i) < 2) |-> !fair_mode_o);
  p_zero_thru_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (shared_w[hog_idx_o*STW +: STW] == '0) |-> !fair_mode_o);
  p_none_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i == '0) |-> (hog_idx_o == '0));
endmodule

// File: tb/tb_slowdown_fair_sel.sv
module tb_slowdown_fair_sel;
  localparam int CLK_PERIOD = 10;
  localparam int NTHR = 4;
  localparam int STW  = 8;
  localparam int THW  = 8;
  localparam int CMAX = 255;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [NTHR-1:0]     stall_i = '0;
  logic [NTHR-1:0]     pend_i = '0;
  logic [NTHR*STW-1:0] alone_i = '0;
  logic [THW-1:0]      thresh_i = '0;
  logic                fair_mode_o;
  logic [1:0]          hog_idx_o;

  slowdown_fair_sel #(.NTHR(NTHR), .STW(STW), .THW(THW)) dut (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .pend_i(pend_i),
    .alone_i(alone_i), .thresh_i(thresh_i),
    .fair_mode_o(fair_mode_o), .hog_idx_o(hog_idx_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic mode; int idx; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  int cnt_m [NTHR];
  int alone_m [NTHR];
  bit done = 0;

  // monitor: compare at the falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (fair_mode_o !== e.mode || int'(hog_idx_o) != e.idx) begin
        errors++;
        $display("FAIL %s: mode=%0b idx=%0d expected mode=%0b idx=%0d",
                 e.tag, fair_mode_o, hog_idx_o, e.mode, e.idx);
      end
    end
  end

  task automatic stall_for(input logic [NTHR-1:0] mask, input int n);
    @(posedge clk); #1;
    stall_i = mask;
    repeat (n) @(posedge clk);
    #1; stall_i = '0;
    for (int i = 0; i < NTHR; i++)
      if (mask[i]) cnt_m[i] = (cnt_m[i] + n > CMAX) ? CMAX : cnt_m[i] + n;
  endtask

  task automatic query(input logic [NTHR-1:0] pend, input int thr, input string tag);
    exp_t e;
    real sd, mx, mn;
    int n;
    @(posedge clk); #1;
    pend_i = pend;
    thresh_i = THW'(thr);
    for (int i = 0; i < NTHR; i++) alone_i[i*STW +: STW] = STW'(alone_m[i]);
    n = 0; e.idx = 0; mx = 0.0; mn = 0.0;
    for (int i = 0; i < NTHR; i++) begin
      if (pend[i]) begin
        sd = real'(cnt_m[i]) / real'(alone_m[i] == 0 ? 1 : alone_m[i]);
        if (n == 0 || sd > mx) begin mx = sd; e.idx = i; end
        if (n == 0 || sd < mn) mn = sd;
        n++;
      end
    end
    e.mode = (n >= 2) && (mx > 0.0) && ((mn == 0.0) || (mx / mn >= real'(thr) / 16.0));
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NTHR; i++) begin cnt_m[i] = 0; alone_m[i] = 10; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    query(4'b0000, 16, "R3 reset idle, no eligible thread");
    query(4'b1111, 16, "R7 all counts zero after reset");

    stall_for(4'b0001, 10);
    query(4'b0011, 32, "R8 fresh count visible, zero minimum");
    stall_for(4'b0010, 20);
    stall_for(4'b0100, 40);
    stall_for(4'b1000, 5);
    query(4'b1111, 32,  "R5 spread 8 over threshold 2");
    query(4'b1111, 255, "R5 spread 8 under threshold 15.9");
    query(4'b0011, 32,  "R5 spread equal to threshold");
    query(4'b0011, 33,  "R5 spread just under threshold");
    query(4'b0100, 16,  "R6 single eligible thread");
    query(4'b1010, 16,  "R4 subset ignores larger thread 2");
    query(4'b1100, 128, "R1 idle thread held its count");

    alone_m[2] = 80;
    query(4'b0110, 48, "R3 differing alone estimates");
    alone_m[2] = 10; alone_m[3] = 0;
    query(4'b1111, 16, "R3 zero alone floored to one");
    alone_m[3] = 10;

    stall_for(4'b0011, 300);
    alone_m[0] = 1; alone_m[1] = 1;
    query(4'b0011, 16, "R2 saturated tie, lowest index");
    query(4'b0111, 16, "R2 saturated thread beats thread 2");

    repeat (3) @(posedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule